// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the hardware side of taking an interrupt. When a request arrives while the processor is idle and interrupts are enabled, it saves the return context on a memory stack. It then switches the processor into its handler state and fetches the handler's start address from a vector slot chosen by the interrupt number.

The block owns the program counter, the stack pointer and the status word. It also owns the memory address and memory data registers that face the bus. The surrounding core writes the three architectural registers through a load port while the block is idle. Stack addresses are logical and are sent through an external address-translation map. The vector slot is addressed physically.

The shared memory bus has a hold (reserve) line, read and write strobes and a ready handshake. The block reserves the bus once for the whole entry and gives it up only when the handler address is in place. A one-cycle completion pulse then tells the core to resume fetching at the new program counter.

Top module: `intr_entry`

## Requirements
- R1: While reset is asserted and after it is released, the program counter and stack pointer read 0, the status word reads 8'h01, and the completion pulse, reserve line and both strobes are low.
- R2: A request is taken only on a clock edge where the block is idle and status bit 1 (interrupt enable) is 1. With that bit clear, a request held for any number of cycles starts no bus activity and changes no register.
- R3: The first item pushed is the program counter as it was when the request was taken. It is written to the translated address of the stack pointer.
- R4: The second item pushed is the status word as it was before entry, zero-extended to the data width. It is written to the translated address of the stack pointer plus one. The stack pointer ends two above its starting value, wrapping modulo 2^ADDR_W.
- R5: After both pushes, status bit 0 (privileged) is 1 and bit 1 (interrupt enable) is 0. All other status bits keep their values.
- R6: The vector is read from the interrupt number, zero-extended to the address width and not translated. The word read becomes the new program counter.
- R7: The reserve line rises once per entry, in the cycle after the request is taken. It stays high until the vector read completes, and it is low in the completion cycle.
- R8: Each bus access keeps its strobe, address and write data steady until ready is seen. Only one strobe is high at a time. An entry takes 7 + 3·L cycles from the accepting edge to the completion pulse when every access waits L cycles for ready.
- R9: The completion pulse lasts exactly one cycle per entry.
- R10: The load port writes the program counter, stack pointer and status word on a clock edge where the block is idle. The port is ignored while an entry is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | 1 | Interrupt request |
| irq_num | input | NUM_W | Interrupt number, used as the vector address |
| ld_en | input | 1 | Load strobe for the architectural registers |
| ld_pc | input | DATA_W | Program counter value to load |
| ld_sp | input | ADDR_W | Stack pointer value to load |
| ld_psw | input | PSW_W | Status word value to load |
| mmu_va | output | ADDR_W | Logical address sent for translation |
| mmu_pa | input | ADDR_W | Translated address, combinational from mmu_va |
| bus_rsv | output | 1 | Bus reserve, held for the whole entry |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | ADDR_W | Memory address register |
| bus_wdata | output | DATA_W | Memory data register, driven as write data |
| bus_rdata | input | DATA_W | Read data |
| bus_rdy | input | 1 | Access complete |
| pc_o | output | DATA_W | Program counter |
| sp_o | output | ADDR_W | Stack pointer |
| psw_o | output | PSW_W | Status word |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the following about the environment:
- The translation map is a pure combinational function of its input.
- Ready is only raised while a strobe is high.
- Read data is valid in the cycle ready is given.

The bench's memory model raises ready only against an active strobe, after a set number of wait cycles, and drops it again the cycle after. Its translation adds a fixed offset, so stack slots and vector slots never overlap. Each vector slot's translated mirror holds a decoy value, so that reading through the map would be visible.

// File: rtl/intr_pkg.sv
package intr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_GRAB     = 3'd1,
      ST_XL_PC    = 3'd2,
      ST_PUSH_PC  = 3'd3,
      ST_XL_PSW   = 3'd4,
      ST_PUSH_PSW = 3'd5,
      ST_VEC_RD   = 3'd6,
      ST_DONE     = 3'd7
   } seq_st_e;

   // one-hot-ish register load controls from sequencer to datapath
   typedef struct packed {
      logic mar_sp;     // MAR <- SP
      logic mar_xl;     // MAR <- translated MAR
      logic mbr_pc;     // MBR <- PC
      logic mbr_psw;    // MBR <- PSW
      logic sp_step;    // SP, MAR <- SP + 1
      logic psw_enter;  // PSW <- privileged, interrupts off; MAR <- vector
      logic rd_load;    // MBR, PC <- read data
   } dp_ctl_t;

endpackage

// File: rtl/intr_inc.sv
module intr_inc #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] y
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   assign y = a + ONE;
endmodule

// File: rtl/intr_fsm.sv
module intr_fsm
   import intr_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    irq_req,
   input  logic    ie,
   input  logic    bus_rdy,
   output dp_ctl_t ctl,
   output logic    accept,
   output logic    idle,
   output logic    bus_rsv,
   output logic    bus_rd,
   output logic    bus_wr,
   output logic    done
);
   seq_st_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign idle   = (state_q == ST_IDLE);
   assign accept = idle && irq_req && ie;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:     if (accept)  state_d = ST_GRAB;
         ST_GRAB:                  state_d = ST_XL_PC;
         ST_XL_PC:                 state_d = ST_PUSH_PC;
         ST_PUSH_PC:  if (bus_rdy) state_d = ST_XL_PSW;
         ST_XL_PSW:                state_d = ST_PUSH_PSW;
         ST_PUSH_PSW: if (bus_rdy) state_d = ST_VEC_RD;
         ST_VEC_RD:   if (bus_rdy) state_d = ST_DONE;
         ST_DONE:                  state_d = ST_IDLE;
         default:                  state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      ctl           = '0;
      ctl.mar_sp    = (state_q == ST_GRAB);
      ctl.mar_xl    = (state_q == ST_XL_PC) || (state_q == ST_XL_PSW);
      ctl.mbr_pc    = (state_q == ST_XL_PC);
      ctl.mbr_psw   = (state_q == ST_XL_PSW);
      ctl.sp_step   = bus_rdy && ((state_q == ST_PUSH_PC) || (state_q == ST_PUSH_PSW));
      ctl.psw_enter = bus_rdy && (state_q == ST_PUSH_PSW);
      ctl.rd_load   = bus_rdy && (state_q == ST_VEC_RD);
   end

   assign bus_wr  = (state_q == ST_PUSH_PC) || (state_q == ST_PUSH_PSW);
   assign bus_rd  = (state_q == ST_VEC_RD);
   assign bus_rsv = !idle && (state_q != ST_DONE);
   assign done    = (state_q == ST_DONE);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle");

   p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr)) else $error("read and write strobes together");

   p_strobe_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |-> bus_rsv) else $error("strobe without reserve");

   p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_rdy) |=> bus_wr) else $error("write dropped before ready");

   p_ie_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !ie) |=> idle) else $error("entry started with interrupts off");

   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_rsv) else $error("reserve held in completion cycle");
endmodule

// File: rtl/intr_dp.sv
module intr_dp
   import intr_pkg::*;
#(
   parameter int          DATA_W   = 16,
   parameter int          ADDR_W   = 8,
   parameter int          NUM_W    = 4,
   parameter int          PSW_W    = 8,
   parameter int          PRIV_BIT = 0,
   parameter int          IE_BIT   = 1,
   parameter logic [15:0] PC_RST   = 16'h0000,
   parameter logic [15:0] SP_RST   = 16'h0000,
   parameter logic [15:0] PSW_RST  = 16'h0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dp_ctl_t           ctl,
   input  logic              accept,
   input  logic              idle,
   input  logic [NUM_W-1:0]  irq_num,
   input  logic              ld_en,
   input  logic [DATA_W-1:0] ld_pc,
   input  logic [ADDR_W-1:0] ld_sp,
   input  logic [PSW_W-1:0]  ld_psw,
   input  logic [ADDR_W-1:0] mmu_pa,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] mar,
   output logic [DATA_W-1:0] mbr,
   output logic [DATA_W-1:0] pc,
   output logic [ADDR_W-1:0] sp,
   output logic [PSW_W-1:0]  psw
);
   localparam int VEC_PAD = ADDR_W - NUM_W;
   localparam int PSW_PAD = DATA_W - PSW_W;

   logic [NUM_W-1:0]  num_q;
   logic [ADDR_W-1:0] sp_inc;
   logic [ADDR_W-1:0] vec_addr;
   logic [DATA_W-1:0] psw_ext;
   logic [PSW_W-1:0]  psw_entry;

   intr_inc #(.W(ADDR_W)) u_sp_inc (.a(sp), .y(sp_inc));

   generate
      if (VEC_PAD == 0) begin : g_vec_full
         assign vec_addr = num_q;
      end else begin : g_vec_pad
         assign vec_addr = {{VEC_PAD{1'b0}}, num_q};
      end
      if (PSW_PAD == 0) begin : g_psw_full
         assign psw_ext = psw;
      end else begin : g_psw_pad
         assign psw_ext = {{PSW_PAD{1'b0}}, psw};
      end
   endgenerate

   always_comb begin
      psw_entry           = psw;
      psw_entry[PRIV_BIT] = 1'b1;
      psw_entry[IE_BIT]   = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) num_q <= '0;
      else if (accept) num_q <= irq_num;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mar <= '0;
      end else if (ctl.mar_sp) begin
         mar <= sp;
      end else if (ctl.mar_xl) begin
         mar <= mmu_pa;
      end else if (ctl.psw_enter) begin
         mar <= vec_addr;
      end else if (ctl.sp_step) begin
         mar <= sp_inc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mbr <= '0;
      end else if (ctl.mbr_pc) begin
         mbr <= pc;
      end else if (ctl.mbr_psw) begin
         mbr <= psw_ext;
      end else if (ctl.rd_load) begin
         mbr <= bus_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc  <= PC_RST[DATA_W-1:0];
         sp  <= SP_RST[ADDR_W-1:0];
         psw <= PSW_RST[PSW_W-1:0];
      end else if (idle && ld_en) begin
         pc  <= ld_pc;
         sp  <= ld_sp;
         psw <= ld_psw;
      end else begin
         if (ctl.sp_step)   sp  <= sp_inc;
         if (ctl.psw_enter) psw <= psw_entry;
         if (ctl.rd_load)   pc  <= bus_rdata;
      end
   end

   p_ld_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && ld_en && !ctl.rd_load) |=> $stable(pc))
      else $error("load port changed PC during entry");

   p_xl_captures_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.mbr_pc |=> (mar == $past(mmu_pa)))
      else $error("stack address not translated");
endmodule

// File: rtl/intr_entry.sv
module intr_entry
   import intr_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 8,
   parameter int NUM_W    = 4,
   parameter int PSW_W    = 8,
   parameter int PRIV_BIT = 0,
   parameter int IE_BIT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic [NUM_W-1:0]  irq_num,
   input  logic              ld_en,
   input  logic [DATA_W-1:0] ld_pc,
   input  logic [ADDR_W-1:0] ld_sp,
   input  logic [PSW_W-1:0]  ld_psw,
   output logic [ADDR_W-1:0] mmu_va,
   input  logic [ADDR_W-1:0] mmu_pa,
   output logic              bus_rsv,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_rdy,
   output logic [DATA_W-1:0] pc_o,
   output logic [ADDR_W-1:0] sp_o,
   output logic [PSW_W-1:0]  psw_o,
   output logic              done
);
   generate
      if (NUM_W > ADDR_W) begin : g_bad_num
         $error("NUM_W must not exceed ADDR_W");
      end
      if (PSW_W > DATA_W) begin : g_bad_psw
         $error("PSW_W must not exceed DATA_W");
      end
      if (PRIV_BIT == IE_BIT || PRIV_BIT >= PSW_W || IE_BIT >= PSW_W) begin : g_bad_bits
         $error("status bit positions invalid");
      end
      if (ADDR_W > 16 || DATA_W > 16 || PSW_W > 16) begin : g_bad_rst
         $error("reset constants limited to 16 bits");
      end
   endgenerate

   dp_ctl_t ctl;
   logic    accept;
   logic    idle;

   intr_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_req (irq_req),
      .ie      (psw_o[IE_BIT]),
      .bus_rdy (bus_rdy),
      .ctl     (ctl),
      .accept  (accept),
      .idle    (idle),
      .bus_rsv (bus_rsv),
      .bus_rd  (bus_rd),
      .bus_wr  (bus_wr),
      .done    (done)
   );

   intr_dp #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .NUM_W    (NUM_W),
      .PSW_W    (PSW_W),
      .PRIV_BIT (PRIV_BIT),
      .IE_BIT   (IE_BIT)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl),
      .accept    (accept),
      .idle      (idle),
      .irq_num   (irq_num),
      .ld_en     (ld_en),
      .ld_pc     (ld_pc),
      .ld_sp     (ld_sp),
      .ld_psw    (ld_psw),
      .mmu_pa    (mmu_pa),
      .bus_rdata (bus_rdata),
      .mar       (bus_addr),
      .mbr       (bus_wdata),
      .pc        (pc_o),
      .sp        (sp_o),
      .psw       (psw_o)
   );

   assign mmu_va = bus_addr;

   p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && !bus_rdy) |=> ($stable(bus_addr) && $stable(bus_wdata)))
      else $error("address or data moved before ready");

   p_psw_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (psw_o[PRIV_BIT] && !psw_o[IE_BIT]))
      else $error("status not in handler state at completion");

   p_rsv_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_rsv) |-> !bus_rd && !bus_wr)
      else $error("reserve rose together with a strobe");
endmodule

// File: tb/intr_entry_bench.sv
`timescale 1ns/1ps
module intr_entry_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0;
   logic [3:0]  irq_num = '0;
   logic        ld_en = 1'b0;
   logic [15:0] ld_pc = '0;
   logic [7:0]  ld_sp = '0;
   logic [7:0]  ld_psw = '0;
   logic [7:0]  mmu_va, mmu_pa;
   logic        bus_rsv, bus_rd, bus_wr, done;
   logic [7:0]  bus_addr, sp_o, psw_o;
   logic [15:0] bus_wdata, bus_rdata, pc_o;
   logic        bus_rdy = 1'b0;

   logic [15:0] mem [256];
   int total = 0, fails = 0;
   int lat_g = 0, wcnt = 0;
   int rsv_rises = 0, done_run = 0, done_max = 0, cyc_all = 0;
   logic rsv_prev = 1'b0;

   // lat[55:52] num[51:48] psw[47:40] sp[39:32] pc[31:16] handler[15:0]
   localparam logic [55:0] ROWS [4] = '{
      {4'd0, 4'd3,  8'h02, 8'h10, 16'h1234, 16'hA000},
      {4'd1, 4'd15, 8'hF2, 8'h20, 16'hBEEF, 16'h0400},
      {4'd2, 4'd0,  8'h03, 8'h7E, 16'h0001, 16'hFFFE},
      {4'd3, 4'd9,  8'h56, 8'hFF, 16'h5A5A, 16'h1357}
   };

   always #2 clk = ~clk;

   intr_entry u_intr_entry (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_num(irq_num),
      .ld_en(ld_en), .ld_pc(ld_pc), .ld_sp(ld_sp), .ld_psw(ld_psw),
      .mmu_va(mmu_va), .mmu_pa(mmu_pa), .bus_rsv(bus_rsv), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .pc_o(pc_o), .sp_o(sp_o),
      .psw_o(psw_o), .done(done));

   function automatic logic [7:0] xl(input logic [7:0] a);
      return a + 8'h80;
   endfunction

   assign mmu_pa    = xl(mmu_va);
   assign bus_rdata = mem[bus_addr];

   always @(posedge clk) if (bus_wr && bus_rdy) mem[bus_addr] = bus_wdata;

   always @(negedge clk) begin
      if (bus_rdy) wcnt = 0;
      if (bus_rd || bus_wr) begin
         bus_rdy = (wcnt == lat_g);
         wcnt++;
      end else begin
         bus_rdy = 1'b0;
         wcnt = 0;
      end
      if (bus_rsv && !rsv_prev) rsv_rises++;
      rsv_prev = bus_rsv;
      if (done) done_run++; else done_run = 0;
      if (done_run > done_max) done_max = done_run;
   end

   always @(posedge clk) begin
      cyc_all++;
      if (cyc_all > 50000) begin
         fails++; total++;
         $display("FAIL watchdog R8: got %0d cycles expected under 50000", cyc_all);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_load(input logic [15:0] p, input logic [7:0] s, input logic [7:0] w);
      @(negedge clk);
      ld_pc = p; ld_sp = s; ld_psw = w; ld_en = 1'b1;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic run_entry(input logic [3:0] num, input int lat, input bit inject,
                            output int cyc);
      bit seen = 1'b0;
      lat_g = lat; rsv_rises = 0; done_max = 0;
      @(negedge clk);
      irq_num = num; irq_req = 1'b1; cyc = 0;
      while (!seen && cyc < 200) begin
         @(posedge clk); cyc++;
         @(negedge clk);
         if (cyc == 1) irq_req = 1'b0;
         if (inject && cyc == 3) begin
            ld_pc = 16'hDEAD; ld_sp = 8'h33; ld_psw = 8'hFF; ld_en = 1'b1;
         end
         if (inject && cyc == 4) ld_en = 1'b0;
         if (done) begin
            seen = 1'b1;
            chk("R7 reserve low at done", {31'd0, bus_rsv}, 32'd0);
         end
      end
      if (!seen) chk("R8 entry completes", 32'd0, 32'd1);
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      int cyc;
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
      repeat (3) @(negedge clk);
      // R1: reset values, sampled during and after reset
      chk("R1 pc", {16'd0, pc_o}, 32'h0);
      chk("R1 psw", {24'd0, psw_o}, 32'h01);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 sp", {24'd0, sp_o}, 32'h0);
      chk("R1 outputs idle", {28'd0, done, bus_rsv, bus_rd, bus_wr}, 32'h0);

      // R2: interrupts disabled after reset, request held 20 cycles
      rsv_rises = 0;
      irq_num = 4'd5; irq_req = 1'b1;
      repeat (20) @(negedge clk);
      irq_req = 1'b0;
      chk("R2 no entry with enable clear", rsv_rises, 0);
      chk("R2 registers untouched", {pc_o, sp_o, psw_o}, {16'h0, 8'h0, 8'h01});

      // table of entries
      for (int i = 0; i < 4; i++) begin
         logic [55:0] r;
         int lat;
         logic [3:0]  num;
         logic [7:0]  psw, sp;
         logic [15:0] pc, h;
         r = ROWS[i];
         lat = int'(r[55:52]); num = r[51:48]; psw = r[47:40]; sp = r[39:32];
         pc = r[31:16]; h = r[15:0];
         mem[{4'h0, num}]     = h;
         mem[xl({4'h0, num})] = ~h;
         mem[xl(sp)]          = 16'h0;
         mem[xl(sp + 8'd1)]   = 16'h0;
         do_load(pc, sp, psw);
         chk("R10 idle load", {pc_o, sp_o, psw_o}, {pc, sp, psw});
         run_entry(num, lat, 1'b0, cyc);
         chk("R3 pc pushed at translated sp", {16'd0, mem[xl(sp)]}, {16'd0, pc});
         chk("R4 psw pushed at translated sp+1", {16'd0, mem[xl(sp + 8'd1)]}, {24'd0, psw});
         chk("R4 sp advanced by two", {24'd0, sp_o}, {24'd0, sp + 8'd2});
         chk("R5 psw handler state", {24'd0, psw_o}, {24'd0, (psw | 8'h01) & ~8'h02});
         chk("R6 pc from untranslated vector", {16'd0, pc_o}, {16'd0, h});
         chk("R8 entry cycle count", cyc, 7 + 3 * lat);
         chk("R7 single reserve interval", rsv_rises, 1);
         chk("R9 done one cycle", done_max, 1);
      end

      // R2: request held after an entry, enable now clear: no second entry
      rsv_rises = 0;
      irq_num = 4'd3; irq_req = 1'b1;
      repeat (20) @(negedge clk);
      irq_req = 1'b0;
      chk("R2 no re-entry after handler state", rsv_rises, 0);

      // R10: load port pulsed mid-entry is ignored
      mem[4'd6] = 16'h0C0C;
      mem[xl(8'h06)] = 16'hF3F3;
      do_load(16'h4242, 8'h40, 8'h0E);
      run_entry(4'd6, 1, 1'b1, cyc);
      chk("R10 pc unaffected by busy load", {16'd0, pc_o}, 32'h0C0C);
      chk("R10 sp unaffected by busy load", {24'd0, sp_o}, 32'h42);
      chk("R10 psw unaffected by busy load", {24'd0, psw_o}, 32'h0D);
      chk("R3 pc pushed with busy load", {16'd0, mem[xl(8'h40)]}, 32'h4242);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule